// File: doc/BRIEF.md
# Double-Buffered DMA Channel

A single DMA channel that shuttles data between one fixed peripheral FIFO address and two memory buffers used in turn. Software programs the channel through a 32-bit register port: a mode/status word (changed only through a bit-set address and a bit-clear address), the peripheral address, and a start address plus a count for each of the two buffers. When the channel is running and the active buffer is enabled, each peripheral request moves one item. The item is read from the source and then written to the destination through a single-beat valid/ready memory master.

When the active buffer's count is used up, the channel marks that buffer done and disables it. It then switches to the other buffer, so software can refill one buffer while the other drains. To stop the channel, software clears the run bit and polls a halt status bit. The halt bit reports 1 only after any transfer already started has finished. A level interrupt is raised while a done flag is set and interrupts are enabled.

Top module: `dbuf_dma_chan`

## Requirements
- R1: Register offsets: 0x00 mode set (reads the mode word), 0x04 mode clear (reads 0), 0x08 peripheral address, 0x0C and 0x14 buffer 0 and buffer 1 start address, 0x10 and 0x18 buffer 0 and buffer 1 count. Every value written to the address, count and peripheral registers reads back one cycle after a read strobe.
- R2: A write to 0x00 ORs the ones of the data into the mode word, and a write to 0x04 clears every bit written as one. Zeros have no effect. Bit 6 (halt), bit 14 and bits 31:24 cannot be written and read 0, except that bit 6 reports the halt status.
- R3: Mode bit 6 (halt) reads 1 exactly when bit 5 (run) is 0 and no transfer is in flight. A transfer already started when run drops still completes, and halt reads 0 until it does.
- R4: Each transfer is a read beat followed by a write beat. With mode bit 12 = 1 the data moves from the peripheral address to the buffer address, and with bit 12 = 0 it moves from the buffer to the peripheral. The written data equals the data read. The address and write flag are held while valid waits for ready.
- R5: After each transfer the active buffer's address grows by the device width in bytes, and its count drops by one. The width field is mode bits 10:9, with 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. Reading the count register returns the remaining count.
- R6: A running channel whose active buffer (mode bit 4: 0 selects buffer 0, 1 selects buffer 1) is enabled with count 0 does three things: it sets that buffer's done flag (bit 1 for buffer 0, bit 3 for buffer 1), clears its enable (bit 0 or bit 2), and toggles bit 4. Run stays set.
- R7: Output irq is high whenever mode bit 7 is 1 and either done flag is set.
- R8: A count register holds the count in bits 15:0 and a 4-bit address extension in bits 19:16, and higher bits are dropped. The extension becomes bits 35:32 of the buffer's memory address. Mode bits 23:20 become bits 35:32 of the peripheral address.
- R9: Both done flags can be set at once. Each flag is cleared by writing a one to it at 0x04, and clearing one flag leaves the other set.
- R10: Peripheral requests are ignored while run is 0 or while the active buffer is disabled. No memory beat is issued in those cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_re |
| per_req | input | 1 | Peripheral request level |
| mem_valid | output | 1 | Memory beat valid |
| mem_write | output | 1 | Beat is a write when 1 |
| mem_addr | output | 36 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken when ready |
| mem_ready | input | 1 | Beat accepted |
| irq | output | 1 | Level interrupt |

## Verification
A register read returns data on the edge after the strobe. A mode write takes effect on the edge that samples it, so the bench always reads back through the register port one strobe later and samples on the falling edge. A transfer launches on the edge that samples per_req and issues its read beat right away. The write beat follows the read handshake, and the address and count update on the write handshake. The done, enable and active-buffer changes come one cycle after that, so the bench allows a fixed margin of idle cycles before it reads the mode word. For the halt case the bench memory model stalls ready, which keeps a transfer in flight while run is cleared, and the bench checks halt both before and after the stall is released.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_e;

  // mode word bit positions
  localparam int MB_EN0  = 0;
  localparam int MB_DN0  = 1;
  localparam int MB_EN1  = 2;
  localparam int MB_DN1  = 3;
  localparam int MB_ACT  = 4;
  localparam int MB_GO   = 5;
  localparam int MB_HALT = 6;
  localparam int MB_IE   = 7;
  localparam int MB_WID  = 9;
  localparam int MB_DIR  = 12;
  localparam int MB_HI   = 20;

  localparam logic [31:0] MODE_WR_MASK = 32'h00FF_BFBF;

  // register offsets
  localparam int OFS_SET   = 'h00;
  localparam int OFS_CLR   = 'h04;
  localparam int OFS_PER   = 'h08;
  localparam int OFS_B0_AD = 'h0C;
  localparam int OFS_B0_CT = 'h10;
  localparam int OFS_B1_AD = 'h14;
  localparam int OFS_B1_CT = 'h18;

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbuf_dma_bufslot.sv
module dbuf_dma_bufslot #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int XW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_addr,
  input  logic [AW-1:0]    ld_addr_val,
  input  logic             ld_cnt,
  input  logic [CW+XW-1:0] ld_cnt_val,
  input  logic             step,
  input  logic [2:0]       step_bytes,
  output logic [AW-1:0]    addr_q,
  output logic [CW-1:0]    cnt_q,
  output logic [XW-1:0]    ext_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (ld_addr)   addr_q <= ld_addr_val;
      else if (step) addr_q <= addr_q + AW'(step_bytes);
      if (ld_cnt) begin
        cnt_q <= ld_cnt_val[CW-1:0];
        ext_q <= ld_cnt_val[CW+XW-1:CW];
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5: a step without a software load removes exactly one item
  p_step_count_r5: assert property (@(posedge clk) disable iff (rst)
    step && !ld_cnt && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R5: a step advances the address by the width in bytes
  p_step_addr_r5: assert property (@(posedge clk) disable iff (rst)
    step && !ld_addr |=> addr_q == $past(addr_q) + AW'($past(step_bytes)));

endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int MW = 36,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          act_sel,
  input  logic          act_en,
  input  logic          act_cnt_zero,
  input  logic          dir_to_mem,
  input  logic [MW-1:0] buf_addr,
  input  logic [MW-1:0] per_addr,
  input  logic          per_req,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [MW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          step,
  output logic          step_sel,
  output logic          finish,
  output logic          busy
);

  eng_state_e    state;
  logic [MW-1:0] dst_q;
  logic          launch;

  assign launch   = (state == ENG_IDLE) && go && act_en && !act_cnt_zero && per_req;
  assign finish   = (state == ENG_IDLE) && go && act_en && act_cnt_zero;
  assign step     = (state == ENG_WR) && mem_ready;
  assign busy     = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dst_q     <= '0;
      step_sel  <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (launch) begin
          mem_valid <= 1'b1;
          mem_write <= 1'b0;
          mem_addr  <= dir_to_mem ? per_addr : buf_addr;
          dst_q     <= dir_to_mem ? buf_addr : per_addr;
          step_sel  <= act_sel;
          state     <= ENG_RD;
        end
        ENG_RD: if (mem_ready) begin
          mem_wdata <= mem_rdata;
          mem_addr  <= dst_q;
          mem_write <= 1'b1;
          state     <= ENG_WR;
        end
        ENG_WR: if (mem_ready) begin
          mem_valid <= 1'b0;
          mem_write <= 1'b0;
          state     <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R4: a beat waiting for ready keeps its address and kind
  p_beat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // R10: a stopped, idle channel issues no beat
  p_no_launch_r10: assert property (@(posedge clk) disable iff (rst)
    !go && !busy |=> !mem_valid);

  // R4: the write beat carries the data the read beat returned
  p_wdata_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_write && mem_ready |=> mem_write && mem_wdata == $past(mem_rdata));

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int XW = 4,
  parameter int OW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [OW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            per_req,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW+XW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic            irq
);

  localparam int MW = AW + XW;
  localparam int NB = 2;

  logic [31:0]   mode_q, mode_nx;
  logic [AW-1:0] per_q;
  logic [AW-1:0] b_addr [NB];
  logic [CW-1:0] b_cnt  [NB];
  logic [XW-1:0] b_ext  [NB];
  logic          eng_step, eng_sel, eng_fin, eng_busy;
  logic          act, halt;
  logic          wr_set, wr_clr;

  assign act    = mode_q[MB_ACT];
  assign halt   = !mode_q[MB_GO] && !eng_busy;
  assign irq    = mode_q[MB_IE] && (mode_q[MB_DN0] || mode_q[MB_DN1]);
  assign wr_set = reg_we && (reg_addr == OW'(OFS_SET));
  assign wr_clr = reg_we && (reg_addr == OW'(OFS_CLR));

  generate
    for (genvar g = 0; g < NB; g++) begin : g_buf
      localparam int OFS_AD = (g == 0) ? OFS_B0_AD : OFS_B1_AD;
      localparam int OFS_CT = (g == 0) ? OFS_B0_CT : OFS_B1_CT;
      dbuf_dma_bufslot #(.AW(AW), .CW(CW), .XW(XW)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .ld_addr     (reg_we && (reg_addr == OW'(OFS_AD))),
        .ld_addr_val (reg_wdata[AW-1:0]),
        .ld_cnt      (reg_we && (reg_addr == OW'(OFS_CT))),
        .ld_cnt_val  (reg_wdata[CW+XW-1:0]),
        .step        (eng_step && (eng_sel == 1'(g))),
        .step_bytes  (width_bytes(mode_q[MB_WID+1:MB_WID])),
        .addr_q      (b_addr[g]),
        .cnt_q       (b_cnt[g]),
        .ext_q       (b_ext[g])
      );
    end
  endgenerate

  dbuf_dma_engine #(.MW(MW), .DW(DW)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .go           (mode_q[MB_GO]),
    .act_sel      (act),
    .act_en       (act ? mode_q[MB_EN1] : mode_q[MB_EN0]),
    .act_cnt_zero (b_cnt[act] == '0),
    .dir_to_mem   (mode_q[MB_DIR]),
    .buf_addr     ({b_ext[act], b_addr[act]}),
    .per_addr     ({mode_q[MB_HI+XW-1:MB_HI], per_q}),
    .per_req      (per_req),
    .mem_ready    (mem_ready),
    .mem_rdata    (mem_rdata),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .step         (eng_step),
    .step_sel     (eng_sel),
    .finish       (eng_fin),
    .busy         (eng_busy)
  );

  always_comb begin
    mode_nx = mode_q;
    if (wr_set) mode_nx = mode_nx | (reg_wdata[31:0] & MODE_WR_MASK);
    if (wr_clr) mode_nx = mode_nx & ~(reg_wdata[31:0] & MODE_WR_MASK);
    if (eng_fin) begin
      if (act) begin
        mode_nx[MB_DN1] = 1'b1;
        mode_nx[MB_EN1] = 1'b0;
      end else begin
        mode_nx[MB_DN0] = 1'b1;
        mode_nx[MB_EN0] = 1'b0;
      end
      mode_nx[MB_ACT] = ~act;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      per_q  <= '0;
    end else begin
      mode_q <= mode_nx;
      if (reg_we && (reg_addr == OW'(OFS_PER))) per_q <= reg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        OW'(OFS_SET):   reg_rdata <= DW'(mode_q | (32'(halt) << MB_HALT));
        OW'(OFS_PER):   reg_rdata <= DW'(per_q);
        OW'(OFS_B0_AD): reg_rdata <= DW'(b_addr[0]);
        OW'(OFS_B0_CT): reg_rdata <= DW'({b_ext[0], b_cnt[0]});
        OW'(OFS_B1_AD): reg_rdata <= DW'(b_addr[1]);
        OW'(OFS_B1_CT): reg_rdata <= DW'({b_ext[1], b_cnt[1]});
        default:        reg_rdata <= '0;
      endcase
    end
  end

  // R6: finishing buffer 0 marks it done, disables it and selects buffer 1
  p_finish_b0_r6: assert property (@(posedge clk) disable iff (rst)
    eng_fin && !reg_we && !act |=> mode_q[MB_DN0] && !mode_q[MB_EN0] && mode_q[MB_ACT] && mode_q[MB_GO]);

  // R6: finishing buffer 1 marks it done, disables it and selects buffer 0
  p_finish_b1_r6: assert property (@(posedge clk) disable iff (rst)
    eng_fin && !reg_we && act |=> mode_q[MB_DN1] && !mode_q[MB_EN1] && !mode_q[MB_ACT]);

  // R7: a completion with interrupts enabled raises irq
  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    eng_fin && mode_q[MB_IE] && !reg_we |=> irq);

  // R3: halt never reports while a beat is outstanding
  p_halt_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !halt);

endmodule

// File: tb/dbuf_dma_chan_test.sv
module dbuf_dma_chan_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic        mem_valid, mem_write;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        irq;
  logic        mem_hold = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [35:0] lg_addr [64];
  logic        lg_wr   [64];
  logic [31:0] lg_data [64];
  int lg_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_dma_chan uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
  );

  function automatic logic [31:0] mem_fn(input logic [35:0] a);
    return a[31:0] ^ 32'hA5A5_0000;
  endfunction

  // memory model: answers one beat every other falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid && !mem_hold) begin
        mem_ready = 1'b1;
        mem_rdata = mem_fn(mem_addr);
        if (lg_n < 64) begin
          lg_addr[lg_n] = mem_addr;
          lg_wr[lg_n]   = mem_write;
          lg_data[lg_n] = mem_wdata;
        end
        lg_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {write offset, write data, read offset, expected read}
  localparam logic [79:0] VEC [10] = '{
    {8'h08, 32'h1000_0040, 8'h08, 32'h1000_0040},
    {8'h0C, 32'h2000_0000, 8'h0C, 32'h2000_0000},
    {8'h10, 32'hFFFF_1234, 8'h10, 32'h000F_1234},
    {8'h14, 32'h3000_0100, 8'h14, 32'h3000_0100},
    {8'h18, 32'h0005_0003, 8'h18, 32'h0005_0003},
    {8'h00, 32'h0000_0A00, 8'h00, 32'h0000_0A40},
    {8'h00, 32'h8000_0040, 8'h00, 32'h0000_0A40},
    {8'h04, 32'h0000_0800, 8'h00, 32'h0000_0240},
    {8'h04, 32'h0000_0000, 8'h00, 32'h0000_0240},
    {8'h00, 32'h0000_0000, 8'h04, 32'h0000_0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    int b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(8'h00, d); chk("R3 reset halt", 36'(d), 36'h40);
    rd(8'h10, d); chk("R1 reset count", 36'(d), 36'h0);
    chk("R7 reset irq", 36'(irq), 36'h0);

    // register vectors (R1, R2, R8)
    for (int i = 0; i < 10; i++) begin
      logic [79:0] v;
      v = VEC[i];
      wr(v[79:72], v[71:40]);
      rd(v[39:32], d);
      chk($sformatf("R1/R2/R8 vector %0d", i), 36'(d), 36'(v[31:0]));
    end

    // peripheral to memory, 16-bit, both buffers
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0100);
    wr(8'h0C, 32'h0000_1000);
    wr(8'h10, 32'h0000_0002);
    wr(8'h14, 32'h0000_2000);
    wr(8'h18, 32'h0003_0001);
    wr(8'h00, 32'h0000_12A5);
    rd(8'h00, d); chk("R3 halt clears with run", 36'(d), 36'h12A5);

    b = lg_n;
    pulse_req(); idle(10);
    chk("R4 read from periph", lg_addr[b], 36'h0_0000_0100);
    chk("R4 read beat kind", 36'(lg_wr[b]), 36'h0);
    chk("R4 write to buffer", lg_addr[b+1], 36'h0_0000_1000);
    chk("R4 write data", 36'(lg_data[b+1]), 36'(mem_fn(36'h100)));
    rd(8'h0C, d); chk("R5 address step 2", 36'(d), 36'h1002);
    rd(8'h10, d); chk("R5 remaining count", 36'(d), 36'h1);

    b = lg_n;
    pulse_req(); idle(10);
    chk("R5 second address", lg_addr[b+1], 36'h0_0000_1002);
    rd(8'h00, d); chk("R6 buffer 0 done, switch", 36'(d), 36'h12B6);
    chk("R7 irq after done", 36'(irq), 36'h1);

    b = lg_n;
    pulse_req(); idle(10);
    chk("R8 extension on buffer 1", lg_addr[b+1], 36'h3_0000_2000);
    rd(8'h00, d); chk("R9 both done, R6 idle with run", 36'(d), 36'h12AA);

    b = lg_n;
    pulse_req(); idle(10);
    chk("R10 disabled buffer ignores request", 36'(lg_n), 36'(b));

    wr(8'h04, 32'h0000_0002);
    rd(8'h00, d); chk("R9 clear done 0 only", 36'(d), 36'h12A8);
    chk("R7 irq held by done 1", 36'(irq), 36'h1);
    wr(8'h04, 32'h0000_0008);
    chk("R7 irq drops", 36'(irq), 36'h0);

    // halt with a transfer in flight
    wr(8'h0C, 32'h0000_4000);
    wr(8'h10, 32'h0000_0001);
    wr(8'h00, 32'h0000_0001);
    mem_hold = 1'b1;
    b = lg_n;
    pulse_req();
    wr(8'h04, 32'h0000_0020);
    rd(8'h00, d); chk("R3 no halt while in flight", 36'(d), 36'h1281);
    chk("R3 beat outstanding", 36'(mem_valid), 36'h1);
    mem_hold = 1'b0;
    idle(10);
    rd(8'h00, d); chk("R3 halt after drain", 36'(d), 36'h12C1);
    chk("R3 in-flight write done", lg_addr[b+1], 36'h0_0000_4000);
    rd(8'h10, d); chk("R3 count consumed", 36'(d), 36'h0);

    b = lg_n;
    wr(8'h10, 32'h0000_0001);
    pulse_req(); idle(6);
    chk("R10 stopped channel ignores request", 36'(lg_n), 36'(b));

    // memory to peripheral, 8-bit, buffer 1, high peripheral bits
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_5000);
    wr(8'h18, 32'h0000_0003);
    wr(8'h00, 32'h0020_0034);
    b = lg_n;
    pulse_req(); idle(10);
    chk("R4 read from buffer", lg_addr[b], 36'h0_0000_5000);
    chk("R8 periph high bits", lg_addr[b+1], 36'h2_0000_0100);
    chk("R4 data to periph", 36'(lg_data[b+1]), 36'(mem_fn(36'h5000)));
    rd(8'h14, d); chk("R5 address step 1", 36'(d), 36'h5001);
    rd(8'h18, d); chk("R5 count after byte", 36'(d), 36'h2);

    summary();
  end

endmodule